// File: doc/BRIEF.md
# Carry-Select Adder with Increment-Derived Alternatives

This block adds two unsigned N-bit operands and a carry-in and yields an N-bit sum and a carry-out. It has no clock and no state. The operand width is cut into groups of G bits. The lowest group is one ripple-carry adder that takes the external carry-in directly.

Every higher group builds only one ripple result, and that result assumes the group receives no carry. The result for an incoming carry of one is made by passing the ripple sum and its group carry through an increment stage that is one bit wider than the ripple adder. A per-group two-way selector then picks one of the two results. The selector is driven by the real carry that leaves the group below.

Because of this, the only long path through the adder is the chain of selectors. The per-group arithmetic runs in parallel. Replacing the second ripple adder with an incrementer saves area in every upper group.

Top module: `csel_inc_adder`

## Requirements
- R1: For every input combination, {carry_out, sum_o} equals the integer value op_a + op_b + carry_in.
- R2: Sum bits [G-1:0] equal the low G bits of op_a[G-1:0] + op_b[G-1:0] + carry_in, whatever the upper operand bits hold.
- R3: When the carry into an upper group is 1, the group's sum slice equals that group's operand slices added plus one. This includes the wrap from all ones to zero, which raises the group carry.
- R4: When the carry into an upper group is 0, the group's sum slice equals the plain sum of that group's operand slices.
- R5: The carry that leaves each group is the select of the group above. A carry raised in group 0 therefore reaches carry_out through every group boundary: op_a all ones, op_b zero and carry_in 1 gives sum_o zero and carry_out 1.
- R6: carry_out is the carry selected in the top group. With all-ones operands and carry_in 1, sum_o is all ones and carry_out is 1.
- R7: N and G are parameters, and N must be a whole multiple of G. The defaults are N=8 and G=4. A 4-bit adder, built as two 2-bit groups or as one 4-bit group, obeys R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First operand, unsigned |
| op_b | input | N | Second operand, unsigned |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | N | Low N bits of the total |
| carry_out | output | 1 | Carry out of the top group |

## Verification
The embedded checks are immediate ones, evaluated whenever the combinational logic settles. Each one is skipped while any operand bit is unknown, so it only judges fully driven inputs. The bench always applies fully defined values and allows a settling delay before it samples. At the default width it sweeps every operand pair under both carry-in values, so every select pattern between groups is exercised.

// File: rtl/csel_pkg.sv
package csel_pkg;
  // number of equal-width groups in an N-bit adder with G-bit groups
  function automatic int grp_count(input int n, input int g);
    return n / g;
  endfunction
endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int G = 4
) (
  input  logic [G-1:0] a_i,
  input  logic [G-1:0] b_i,
  input  logic         c_i,
  output logic [G-1:0] s_o,
  output logic         c_o
);
  localparam int W = G + 1;

  logic [G:0] chain;
  assign chain[0] = c_i;

  for (genvar i = 0; i < G; i++) begin : g_fa
    logic half;
    assign half         = a_i[i] ^ b_i[i];
    assign s_o[i]       = half ^ chain[i];
    assign chain[i + 1] = (a_i[i] & b_i[i]) | (chain[i] & half);
  end

  assign c_o = chain[G];

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      // R1
      rca_sum_chk: assert ({c_o, s_o} == W'(a_i) + W'(b_i) + W'(c_i))
        else $error("ripple group sum mismatch");
    end
  end
endmodule

// File: rtl/csel_excess1.sv
module csel_excess1 #(
  parameter int W = 5
) (
  input  logic [W-1:0] v_i,
  output logic [W-1:0] v_o
);
  // low_ones[i] is high when every bit below i is one
  logic [W-1:0] low_ones;
  assign low_ones[0] = 1'b1;

  for (genvar i = 1; i < W; i++) begin : g_pre
    assign low_ones[i] = low_ones[i - 1] & v_i[i - 1];
  end

  for (genvar i = 0; i < W; i++) begin : g_flip
    assign v_o[i] = v_i[i] ^ low_ones[i];
  end

  always_comb begin
    if (!$isunknown(v_i)) begin
      // R3
      inc_val_chk: assert (v_o == v_i + W'(1))
        else $error("increment stage mismatch");
    end
  end
endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int G = 4
) (
  input  logic [G-1:0] a_i,
  input  logic [G-1:0] b_i,
  input  logic         sel_i,
  output logic [G-1:0] s_o,
  output logic         c_o
);
  localparam int W = G + 1;

  logic [G-1:0] s_zero;
  logic         c_zero;
  logic [W-1:0] dir_res;
  logic [W-1:0] alt_res;
  logic [W-1:0] pick;

  csel_ripple #(.G(G)) rca_u (
    .a_i(a_i), .b_i(b_i), .c_i(1'b0), .s_o(s_zero), .c_o(c_zero)
  );

  assign dir_res = {c_zero, s_zero};

  csel_excess1 #(.W(W)) inc_u (
    .v_i(dir_res), .v_o(alt_res)
  );

  for (genvar i = 0; i < W; i++) begin : g_mux
    assign pick[i] = sel_i ? alt_res[i] : dir_res[i];
  end

  assign s_o = pick[G-1:0];
  assign c_o = pick[G];

  always_comb begin
    if (!$isunknown({a_i, b_i, sel_i})) begin
      // R4
      grp_sel_chk: assert ({c_o, s_o} == W'(a_i) + W'(b_i) + W'(sel_i))
        else $error("group selection mismatch");
      // R5
      alt_carry_chk: assert (!c_zero || alt_res[G])
        else $error("carry-one alternative lost a carry");
    end
  end
endmodule

// File: rtl/csel_inc_adder.sv
module csel_inc_adder #(
  parameter int N = 8,
  parameter int G = 4
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic         carry_in,
  output logic [N-1:0] sum_o,
  output logic         carry_out
);
  import csel_pkg::*;

  localparam int NG = grp_count(N, G);
  localparam int NW = N + 1;
  localparam int GW = G + 1;

  // gc[k] is the carry entering group k
  logic [NG:0] gc;
  assign gc[0] = carry_in;

  csel_ripple #(.G(G)) base_u (
    .a_i(op_a[G-1:0]), .b_i(op_b[G-1:0]), .c_i(gc[0]),
    .s_o(sum_o[G-1:0]), .c_o(gc[1])
  );

  for (genvar k = 1; k < NG; k++) begin : g_up
    csel_group #(.G(G)) grp_u (
      .a_i(op_a[k*G +: G]), .b_i(op_b[k*G +: G]), .sel_i(gc[k]),
      .s_o(sum_o[k*G +: G]), .c_o(gc[k + 1])
    );
  end

  assign carry_out = gc[NG];

  always_comb begin
    if (!$isunknown({op_a, op_b, carry_in})) begin
      // R1
      total_sum_chk: assert ({carry_out, sum_o} == NW'(op_a) + NW'(op_b) + NW'(carry_in))
        else $error("adder total mismatch");
      // R2
      low_grp_chk: assert (GW'(sum_o[G-1:0]) ==
                           ((GW'(op_a[G-1:0]) + GW'(op_b[G-1:0]) + GW'(carry_in)) & GW'((1 << G) - 1)))
        else $error("low group mismatch");
    end
  end
endmodule

// File: tb/csel_inc_adder_tb_top.sv
module csel_inc_adder_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] a8, b8, s8;
  logic       c8, co8;
  logic [3:0] a4, b4, s4p, s4w;
  logic       c4, co4p, co4w;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  csel_inc_adder dut_i (
    .op_a(a8), .op_b(b8), .carry_in(c8), .sum_o(s8), .carry_out(co8)
  );
  csel_inc_adder #(.N(4), .G(2)) dut_n4_i (
    .op_a(a4), .op_b(b4), .carry_in(c4), .sum_o(s4p), .carry_out(co4p)
  );
  csel_inc_adder #(.N(4), .G(4)) dut_w4_i (
    .op_a(a4), .op_b(b4), .carry_in(c4), .sum_o(s4w), .carry_out(co4w)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic drive8(input int a, input int b, input int c);
    a8 = 8'(a); b8 = 8'(b); c8 = 1'(c);
    #1;
  endtask

  task automatic t_zero();
    drive8(0, 0, 0);
    chk("R1 zero inputs", {23'd0, co8, s8}, 0);
  endtask

  task automatic t_low_isolation();
    // low nibbles 9 + 8 + 1 = 18 -> low sum 2
    for (int u = 0; u < 16; u += 5) begin
      drive8((u << 4) | 9, ((15 - u) << 4) | 8, 1);
      chk("R2 low group isolated", int'(s8[3:0]), 2);
    end
  endtask

  task automatic t_upper_plus_one();
    drive8(8'h3F, 8'h41, 0);
    chk("R3 upper plus one", int'(s8[7:4]), 8);
    drive8(8'hF8, 8'h08, 0);
    chk("R3 upper wrap sum", int'(s8), 0);
    chk("R3 upper wrap carry", int'(co8), 1);
  endtask

  task automatic t_upper_direct();
    drive8(8'h37, 8'h42, 0);
    chk("R4 upper direct", int'(s8[7:4]), 7);
    chk("R4 total", {23'd0, co8, s8}, 8'h79);
  endtask

  task automatic t_chain_all();
    drive8(8'hFF, 8'h00, 1);
    chk("R5 chain sum", int'(s8), 0);
    chk("R5 chain carry", int'(co8), 1);
  endtask

  task automatic t_max();
    drive8(8'hFF, 8'hFF, 1);
    chk("R6 max sum", int'(s8), 8'hFF);
    chk("R6 max carry", int'(co8), 1);
  endtask

  task automatic t_exhaustive8();
    int bad = 0;
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++) begin
          drive8(a, b, c);
          if ({23'd0, co8, s8} != a + b + c) begin
            bad++;
            if (bad < 8)
              $display("FAIL R1 a=%0h b=%0h c=%0d got=%0h exp=%0h",
                       a, b, c, {co8, s8}, a + b + c);
          end
        end
    n_chk++;
    if (bad != 0) n_fail++;
  endtask

  task automatic t_width4();
    int bad = 0;
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          a4 = 4'(a); b4 = 4'(b); c4 = 1'(c);
          #1;
          if ({27'd0, co4p, s4p} != a + b + c || {27'd0, co4w, s4w} != a + b + c) begin
            bad++;
            if (bad < 8)
              $display("FAIL R7 a=%0h b=%0h c=%0d got=%0h/%0h exp=%0h",
                       a, b, c, {co4p, s4p}, {co4w, s4w}, a + b + c);
          end
        end
    n_chk++;
    if (bad != 0) n_fail++;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 190000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got=%0d exp=<190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    a4 = '0; b4 = '0; c4 = 1'b0;
    @(negedge clk);
    t_zero();
    t_low_isolation();
    t_upper_plus_one();
    t_upper_direct();
    t_chain_all();
    t_max();
    t_exhaustive8();
    t_width4();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule